// File: doc/BRIEF.md
# Even-Shift Radicand Normaliser

This block holds the two helper stages that sit on either side of a fixed-point square-root core. The front stage takes an unsigned radicand and shifts it left by the largest even amount that still keeps its value in range. After this shift, the most significant one lands in one of the two top bit positions. The stage outputs the shifted value and the shift count, so the core always works on a value with as many significant bits as possible.

The back stage takes the core's fixed-point root together with the shift count that the front stage produced. It shifts the root right by half that count, which is exact because the count is always even. It then splits the result into an integer field and a fraction field. The root computation itself lies outside the block.

Each stage is either purely combinational or has one register stage, chosen by its own parameter. With one register stage, the shift count and data are registered together and the valid flag is delayed by one cycle.

Top module: `radicand_normaliser`

## Requirements
- R1: The normalised value is `PW = W + (W mod 2)` bits wide; an odd-width radicand is zero-extended by one bit at the top before the shift count is found.
- R2: For a nonzero radicand, `norm_shift` is even and is the largest even count for which the shifted value still fits in `PW` bits; afterwards at least one of the two top bits of `norm_value` is one.
- R3: `norm_value` equals the padded radicand shifted left by `norm_shift`, with no one bit lost.
- R4: A zero radicand gives `norm_value` = 0 and `norm_shift` = 0.
- R5: The back stage shifts `root_in` right by `root_shift / 2` bit positions.
- R6: `out_int` is the upper `PW/2` bits and `out_frac` the lower `FRAC_W` bits of the shifted root; bits shifted out below the fraction field are truncated.
- R7: With `LAT_FRONT` = 0 the front outputs follow the inputs in the same cycle; with any value of 1 or more they appear one clock after `rad_valid`, and `norm_valid` is `rad_valid` delayed by one cycle.
- R8: With `LAT_BACK` = 0 the back outputs follow the inputs in the same cycle; with any value of 1 or more they appear one clock after `root_valid`, and `out_valid` is `root_valid` delayed by one cycle.
- R9: While the asynchronous, active-high `rst` is asserted, the registered valid outputs are 0 and the registered data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| rad_valid | input | 1 | Radicand valid strobe |
| rad_in | input | W | Unsigned radicand |
| norm_valid | output | 1 | Normalised result valid |
| norm_value | output | PW | Radicand after the even left shift |
| norm_shift | output | SW | Left shift count applied (always even) |
| root_valid | input | 1 | Root valid strobe |
| root_in | input | PW/2+FRAC_W | Fixed-point root from the core, FRAC_W fraction bits |
| root_shift | input | SW | Shift count that belongs to this root |
| out_valid | output | 1 | Final root valid |
| out_int | output | PW/2 | Integer part of the de-normalised root |
| out_frac | output | FRAC_W | Fraction part of the de-normalised root |

## Verification
The bench drives radicands of one and two, and values just below and at the two-bit boundary. An odd-width instance is included to show that the padding bit is counted. A count taken straight from the leading zeros would give an odd shift, and an off-by-one would overflow the top bit; either error shows up as a wrong shift or value. A zero radicand is checked on its own, because a naive leading-zero count would report the full width as the shift. On the back path, large shifts force fraction bits out of the bottom; a design that rounded them, or shifted by the full count, would give a wrong fraction. Latency settings of zero, one and above one are each checked against the cycle in which data and valid should appear.

// File: rtl/radicand_normaliser.sv
module radicand_normaliser #(
  parameter int W         = 12,
  parameter int LAT_FRONT = 1,
  parameter int LAT_BACK  = 1,
  parameter int PW        = W + (W % 2),
  parameter int FRAC_W    = PW / 2,
  parameter int SW        = $clog2(PW + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rad_valid,
  input  logic [W-1:0]           rad_in,
  output logic                   norm_valid,
  output logic [PW-1:0]          norm_value,
  output logic [SW-1:0]          norm_shift,
  input  logic                   root_valid,
  input  logic [PW/2+FRAC_W-1:0] root_in,
  input  logic [SW-1:0]          root_shift,
  output logic                   out_valid,
  output logic [PW/2-1:0]        out_int,
  output logic [FRAC_W-1:0]      out_frac
);
  localparam int HW = PW / 2;
  localparam int RW = HW + FRAC_W;

  logic [PW-1:0] padded;
  logic [SW-1:0] lz, shift_c;
  logic          found;
  logic [PW-1:0] value_c;
  logic [RW-1:0] root_sh;

  assign padded = PW'(rad_in);

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = PW - 1; i >= 0; i--) begin
      if (!found) begin
        if (padded[i]) found = 1'b1;
        else           lz    = lz + SW'(1);
      end
    end
  end

  assign shift_c = found ? {lz[SW-1:1], 1'b0} : '0;
  assign value_c = padded << shift_c;
  assign root_sh = root_in >> root_shift[SW-1:1];

  generate
    if (LAT_FRONT == 0) begin : g_front_comb
      assign norm_valid = rad_valid;
      assign norm_value = value_c;
      assign norm_shift = shift_c;
    end else begin : g_front_reg
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          norm_valid <= 1'b0;
          norm_value <= '0;
          norm_shift <= '0;
        end else begin
          norm_valid <= rad_valid;
          if (rad_valid) begin
            norm_value <= value_c;
            norm_shift <= shift_c;
          end
        end
      end
      // R7
      front_delay_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> norm_valid == $past(rad_valid));
    end

    if (LAT_BACK == 0) begin : g_back_comb
      assign out_valid = root_valid;
      assign out_int   = root_sh[RW-1:FRAC_W];
      assign out_frac  = root_sh[FRAC_W-1:0];
    end else begin : g_back_reg
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          out_valid <= 1'b0;
          out_int   <= '0;
          out_frac  <= '0;
        end else begin
          out_valid <= root_valid;
          if (root_valid) begin
            out_int  <= root_sh[RW-1:FRAC_W];
            out_frac <= root_sh[FRAC_W-1:0];
          end
        end
      end
      // R8
      back_delay_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid == $past(root_valid));
    end
  endgenerate

  // R2
  even_shift_chk: assert property (@(posedge clk) disable iff (rst)
    norm_valid |-> !norm_shift[0]);

  // R2
  top_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (norm_valid && norm_value != '0) |-> norm_value[PW-1:PW-2] != 2'b00);

  // R4
  zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (norm_valid && norm_value == '0) |-> norm_shift == '0);

  // R3
  shift_range_chk: assert property (@(posedge clk) disable iff (rst)
    norm_valid |-> norm_shift <= SW'(PW - 2));
endmodule

// File: tb/test_radicand_normaliser.sv
`timescale 1ns/100ps
module test_radicand_normaliser;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // main instance: W=12, both stages registered
  logic        a_rv = 0;  logic [11:0] a_rad = '0;
  logic        a_nv;      logic [11:0] a_nval; logic [3:0] a_nsh;
  logic        a_tv = 0;  logic [11:0] a_root = '0; logic [3:0] a_rsh = '0;
  logic        a_ov;      logic [5:0]  a_int;  logic [5:0] a_frac;

  // odd instance: W=7, front combinational, back latency 3 (acts as 1)
  logic        b_rv = 0;  logic [6:0] b_rad = '0;
  logic        b_nv;      logic [7:0] b_nval; logic [3:0] b_nsh;
  logic        b_tv = 0;  logic [7:0] b_root = '0; logic [3:0] b_rsh = '0;
  logic        b_ov;      logic [3:0] b_int;  logic [3:0] b_frac;

  radicand_normaliser #(.W(12), .LAT_FRONT(1), .LAT_BACK(1)) i_radicand_normaliser (
    .clk(clk), .rst(rst), .rad_valid(a_rv), .rad_in(a_rad),
    .norm_valid(a_nv), .norm_value(a_nval), .norm_shift(a_nsh),
    .root_valid(a_tv), .root_in(a_root), .root_shift(a_rsh),
    .out_valid(a_ov), .out_int(a_int), .out_frac(a_frac));

  radicand_normaliser #(.W(7), .LAT_FRONT(0), .LAT_BACK(3)) i_radicand_normaliser_odd (
    .clk(clk), .rst(rst), .rad_valid(b_rv), .rad_in(b_rad),
    .norm_valid(b_nv), .norm_value(b_nval), .norm_shift(b_nsh),
    .root_valid(b_tv), .root_in(b_root), .root_shift(b_rsh),
    .out_valid(b_ov), .out_int(b_int), .out_frac(b_frac));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_shift(input logic [63:0] x, input int pw);
    int s = 0;
    if (x == 0) return 0;
    while (x < (64'd1 << (pw - s - 2))) s += 2;
    return s;
  endfunction

  task automatic front_main(input logic [11:0] x);
    int s = exp_shift(64'(x), 12);
    @(negedge clk); a_rv = 1; a_rad = x;
    chk("R7 valid not early", 64'(a_nv), 64'd0);
    @(negedge clk); a_rv = 0; a_rad = '0;
    chk("R7 valid after one cycle", 64'(a_nv), 64'd1);
    chk(x == 0 ? "R4 zero shift" : "R2 shift", 64'(a_nsh), 64'(s));
    chk(x == 0 ? "R4 zero value" : "R3 value", 64'(a_nval), 64'((64'(x) << s) & 64'hFFF));
    @(negedge clk);
    chk("R7 valid one cycle wide", 64'(a_nv), 64'd0);
  endtask

  task automatic front_odd(input logic [6:0] x);
    int s = exp_shift(64'(x), 8);
    @(negedge clk); b_rv = 1; b_rad = x;
    #1;
    chk("R7 comb valid", 64'(b_nv), 64'd1);
    chk(x == 0 ? "R4 zero shift odd" : "R1 shift odd width", 64'(b_nsh), 64'(s));
    chk("R1 value odd width", 64'(b_nval), 64'((64'(x) << s) & 64'hFF));
    b_rv = 0;
  endtask

  task automatic back_main(input logic [11:0] r, input logic [3:0] sh);
    logic [11:0] e = r >> (sh / 2);
    @(negedge clk); a_tv = 1; a_root = r; a_rsh = sh;
    @(negedge clk); a_tv = 0; a_root = '0; a_rsh = '0;
    chk("R8 valid after one cycle", 64'(a_ov), 64'd1);
    chk("R5 R6 integer part", 64'(a_int), 64'(e[11:6]));
    chk("R6 fraction part", 64'(a_frac), 64'(e[5:0]));
    @(negedge clk);
    chk("R8 valid one cycle wide", 64'(a_ov), 64'd0);
  endtask

  task automatic back_odd(input logic [7:0] r, input logic [3:0] sh);
    logic [7:0] e = r >> (sh / 2);
    @(negedge clk); b_tv = 1; b_root = r; b_rsh = sh;
    #1;
    chk("R8 latency above one not comb", 64'(b_ov), 64'd0);
    @(negedge clk); b_tv = 0;
    chk("R8 latency above one acts as one", 64'(b_ov), 64'd1);
    chk("R5 integer odd", 64'(b_int), 64'(e[7:4]));
    chk("R6 fraction odd", 64'(b_frac), 64'(e[3:0]));
  endtask

  initial begin
    #1;
    chk("R9 reset norm_valid", 64'(a_nv), 64'd0);
    chk("R9 reset norm_value", 64'(a_nval), 64'd0);
    chk("R9 reset out_valid", 64'(a_ov), 64'd0);
    chk("R9 reset out_int", 64'(a_int), 64'd0);
    repeat (3) @(negedge clk);
    rst = 0;
    front_main(12'h000);
    front_main(12'h001);
    front_main(12'h002);
    front_main(12'h003);
    front_main(12'h200);
    front_main(12'h400);
    front_main(12'h035);
    front_main(12'hFFF);
    front_odd(7'h00);
    front_odd(7'h01);
    front_odd(7'h10);
    front_odd(7'h20);
    front_odd(7'h7F);
    back_main(12'hABC, 4'd0);
    back_main(12'hABC, 4'd4);
    back_main(12'hFFF, 4'd10);
    back_main(12'h801, 4'd2);
    back_odd(8'hC3, 4'd6);
    back_odd(8'h5A, 4'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule